// File: doc/BRIEF.md
# Value-Based Load Replay Checker

This block enforces load ordering by comparing values instead of searching a load queue whenever a store arrives. A load that executes early records its tag, its translated address and the data it obtained. Stores and external invalidations seen afterwards are snooped against every recorded address. A hit marks the matching load as suspect. When the load reaches commit, an unmarked load retires straight away. A marked load re-reads the data cache at its recorded address through the read port that committing stores also use. The new data is compared with the recorded data, and the load either retires or raises a squash that carries its tag.

The commit stage presents one load tag at a time and holds it while the stall output is high. A committing store always wins the shared cache port. The cache answers a read in the cycle after the request. A parameter can force every load to replay, which turns the filter off.

Top module: `lrc_replay_checker`

## Requirements
- R1: A commit of a recorded, unmarked load is accepted in its request cycle without a cache read, and the retire output with that load's tag appears one cycle later.
- R2: A snoop that hits a recorded load's 8-byte word marks that load. Its later commit raises the cache read enable, carrying the recorded address, in the cycle the commit is accepted.
- R3: While the store-commit input is high, a marked load issues no cache read and the stall output is high. The read goes out in the first cycle the store input is low. An unmarked load is not delayed by store commit.
- R4: If the cache data returned one cycle after the replay read equals the recorded data, the retire output is high with the load's tag in that cycle and the squash output is low.
- R5: If the returned data differs from the recorded data, the squash output is high with the load's tag in that cycle and the retire output is low.
- R6: A snoop to a different 8-byte word does not mark a load. Its commit retires without a cache read.
- R7: Snoop matching ignores the address bits below bit 3, so a snoop to another byte of the same 8-byte word marks the load.
- R8: In the cycle after a replay read the stall output is high, and no new commit is accepted. Unmarked loads can be accepted in consecutive cycles, and each retires one cycle after its acceptance.
- R9: After reset, retire, squash, cache read enable and stall are all low.
- R10: A snoop in the same cycle as a load's recording, to that load's word, marks the load.
- R11: Recording a new load into a slot that was marked clears the mark, so the new load's commit retires without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rec_valid | input | 1 | Load completed; record it |
| rec_tag | input | 4 | Sequence tag and slot of the recorded load |
| rec_addr | input | 32 | Translated load address |
| rec_data | input | 64 | Data the load obtained |
| snp_valid | input | 1 | Store or external invalidation seen |
| snp_addr | input | 32 | Address of the snooped write |
| cmt_valid | input | 1 | Load at commit asks to retire |
| cmt_tag | input | 4 | Tag of the committing load |
| st_cmt_valid | input | 1 | A store commit owns the cache port this cycle |
| cache_rd_en | output | 1 | Replay read request on the shared port |
| cache_rd_addr | output | 32 | Replay read address |
| cache_rd_data | input | 64 | Cache data, one cycle after the request |
| cmt_stall | output | 1 | Commit must hold its request |
| retire_valid | output | 1 | Load may retire |
| squash_valid | output | 1 | Pipeline must be flushed from this load |
| result_tag | output | 4 | Tag for retire or squash |

## Verification
The read enable, its address and the stall output depend combinationally on the commit request, so they are due in the request cycle itself. Retire, squash and the result tag are due exactly one clock edge after the commit is accepted, which is the same cycle as the cache reply. The bench drives every input at the falling edge and samples 1 ns later. That places each same-cycle check after the inputs settle, and it places each result check in the low phase after the single registering edge. No check is taken across two edges.

// File: rtl/lrc_pkg.sv
package lrc_pkg;
   typedef enum logic [1:0] {
      OUT_NONE   = 2'd0,
      OUT_RETIRE = 2'd1,
      OUT_SQUASH = 2'd2
   } lrc_outcome_e;
endpackage

// File: rtl/lrc_entry_file.sv
module lrc_entry_file #(
   parameter int DEPTH     = 16,
   parameter int AW        = 32,
   parameter int DW        = 64,
   parameter int WORD_LSB  = 3,
   parameter bit FORCE_ALL = 1'b0,
   localparam int TW       = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [TW-1:0] wr_tag,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data,
   input  logic          snp_en,
   input  logic [AW-1:0] snp_addr,
   input  logic          rel_en,
   input  logic [TW-1:0] rel_tag,
   input  logic [TW-1:0] rd_tag,
   output logic [AW-1:0] rd_addr,
   output logic [DW-1:0] rd_data,
   output logic          rd_flag
);
   logic [AW-1:0] addr_all [DEPTH];
   logic [DW-1:0] data_all [DEPTH];
   logic [DEPTH-1:0] flag_all;

   wire same_word_new = snp_en &&
      (snp_addr[AW-1:WORD_LSB] == wr_addr[AW-1:WORD_LSB]);

   for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      logic          v_q;
      logic          f_q;
      logic [AW-1:0] a_q;
      logic [DW-1:0] d_q;
      wire wr_me  = wr_en && (wr_tag == TW'(i));
      wire rel_me = rel_en && (rel_tag == TW'(i));
      wire hit    = snp_en && v_q &&
                    (a_q[AW-1:WORD_LSB] == snp_addr[AW-1:WORD_LSB]);

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            v_q <= 1'b0;
            f_q <= 1'b0;
         end else if (wr_me) begin
            v_q <= 1'b1;
            f_q <= same_word_new;
         end else begin
            if (rel_me) v_q <= 1'b0;
            if (hit)    f_q <= 1'b1;
         end
      end

      always_ff @(posedge clk) begin
         if (wr_me) begin
            a_q <= wr_addr;
            d_q <= wr_data;
         end
      end

      assign addr_all[i] = a_q;
      assign data_all[i] = d_q;
      assign flag_all[i] = f_q;

      // R2: a snoop hit on a held entry leaves it marked
      assert_snoop_marks_R2: assert property (@(posedge clk) disable iff (!rst_n)
         (hit && !wr_me) |=> f_q);
      // R11: a fresh record without a snoop leaves the entry unmarked
      assert_record_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_me && !snp_en) |=> !f_q);
   end

   assign rd_addr = addr_all[rd_tag];
   assign rd_data = data_all[rd_tag];

   if (FORCE_ALL) begin : g_always_replay
      assign rd_flag = 1'b1;
   end else begin : g_filtered
      assign rd_flag = flag_all[rd_tag];
   end
endmodule

// File: rtl/lrc_replay_ctrl.sv
module lrc_replay_ctrl
   import lrc_pkg::*;
#(
   parameter int AW = 32,
   parameter int DW = 64,
   parameter int TW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cmt_valid,
   input  logic [TW-1:0] cmt_tag,
   input  logic          ent_flag,
   input  logic [AW-1:0] ent_addr,
   input  logic [DW-1:0] ent_data,
   input  logic          st_cmt_valid,
   output logic          cache_rd_en,
   output logic [AW-1:0] cache_rd_addr,
   input  logic [DW-1:0] cache_rd_data,
   output logic          accept,
   output logic          cmt_stall,
   output logic          retire_valid,
   output logic          squash_valid,
   output logic [TW-1:0] result_tag
);
   logic          pend_q, skip_q;
   logic [TW-1:0] tag_q;
   logic [DW-1:0] want_q;
   lrc_outcome_e  outcome;

   assign cmt_stall     = pend_q || (cmt_valid && ent_flag && st_cmt_valid);
   assign accept        = cmt_valid && !cmt_stall;
   assign cache_rd_en   = accept && ent_flag;
   assign cache_rd_addr = ent_addr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         skip_q <= 1'b0;
      end else begin
         pend_q <= accept && ent_flag;
         skip_q <= accept && !ent_flag;
      end
   end

   always_ff @(posedge clk) begin
      if (accept) begin
         tag_q  <= cmt_tag;
         want_q <= ent_data;
      end
   end

   always_comb begin
      outcome = OUT_NONE;
      if (skip_q)
         outcome = OUT_RETIRE;
      else if (pend_q)
         outcome = (cache_rd_data == want_q) ? OUT_RETIRE : OUT_SQUASH;
   end

   assign retire_valid = (outcome == OUT_RETIRE);
   assign squash_valid = (outcome == OUT_SQUASH);
   assign result_tag   = tag_q;

   assert_store_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
      st_cmt_valid |-> !cache_rd_en);
   assert_single_outcome_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(retire_valid && squash_valid));
   assert_result_due_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cache_rd_en |=> (retire_valid || squash_valid));
   assert_hold_after_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cache_rd_en |=> cmt_stall);
   assert_retire_no_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !cache_rd_en) |=> (retire_valid && !squash_valid));
endmodule

// File: rtl/lrc_replay_checker.sv
module lrc_replay_checker #(
   parameter int DEPTH        = 16,
   parameter int AW           = 32,
   parameter int DW           = 64,
   parameter bit ALWAYS_REPLAY = 1'b0,
   localparam int TW          = $clog2(DEPTH),
   localparam int WORD_LSB    = $clog2(DW / 8)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rec_valid,
   input  logic [TW-1:0] rec_tag,
   input  logic [AW-1:0] rec_addr,
   input  logic [DW-1:0] rec_data,
   input  logic          snp_valid,
   input  logic [AW-1:0] snp_addr,
   input  logic          cmt_valid,
   input  logic [TW-1:0] cmt_tag,
   input  logic          st_cmt_valid,
   output logic          cache_rd_en,
   output logic [AW-1:0] cache_rd_addr,
   input  logic [DW-1:0] cache_rd_data,
   output logic          cmt_stall,
   output logic          retire_valid,
   output logic          squash_valid,
   output logic [TW-1:0] result_tag
);
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("lrc_replay_checker: DEPTH must be a power of two, at least 2");
   end
   if (DW < 8 || (DW % 8) != 0) begin : g_bad_dw
      $error("lrc_replay_checker: DW must be a whole number of bytes");
   end
   if (AW <= WORD_LSB) begin : g_bad_aw
      $error("lrc_replay_checker: AW too narrow for the data word");
   end

   logic          ent_flag, accept;
   logic [AW-1:0] ent_addr;
   logic [DW-1:0] ent_data;

   lrc_entry_file #(
      .DEPTH(DEPTH), .AW(AW), .DW(DW), .WORD_LSB(WORD_LSB), .FORCE_ALL(ALWAYS_REPLAY)
   ) u_file (
      .clk(clk), .rst_n(rst_n),
      .wr_en(rec_valid), .wr_tag(rec_tag), .wr_addr(rec_addr), .wr_data(rec_data),
      .snp_en(snp_valid), .snp_addr(snp_addr),
      .rel_en(accept), .rel_tag(cmt_tag),
      .rd_tag(cmt_tag), .rd_addr(ent_addr), .rd_data(ent_data), .rd_flag(ent_flag)
   );

   lrc_replay_ctrl #(.AW(AW), .DW(DW), .TW(TW)) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .cmt_valid(cmt_valid), .cmt_tag(cmt_tag),
      .ent_flag(ent_flag), .ent_addr(ent_addr), .ent_data(ent_data),
      .st_cmt_valid(st_cmt_valid),
      .cache_rd_en(cache_rd_en), .cache_rd_addr(cache_rd_addr),
      .cache_rd_data(cache_rd_data),
      .accept(accept), .cmt_stall(cmt_stall),
      .retire_valid(retire_valid), .squash_valid(squash_valid),
      .result_tag(result_tag)
   );
endmodule

// File: tb/sim_lrc_replay_checker.sv
module sim_lrc_replay_checker;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rec_valid = 1'b0;
   logic [3:0]  rec_tag = '0;
   logic [31:0] rec_addr = '0;
   logic [63:0] rec_data = '0;
   logic        snp_valid = 1'b0;
   logic [31:0] snp_addr = '0;
   logic        cmt_valid = 1'b0;
   logic [3:0]  cmt_tag = '0;
   logic        st_cmt_valid = 1'b0;
   logic        cache_rd_en;
   logic [31:0] cache_rd_addr;
   logic [63:0] cache_rd_data = '0;
   logic        cmt_stall, retire_valid, squash_valid;
   logic [3:0]  result_tag;

   int n_chk = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   lrc_replay_checker u0 (
      .clk(clk), .rst_n(rst_n),
      .rec_valid(rec_valid), .rec_tag(rec_tag), .rec_addr(rec_addr), .rec_data(rec_data),
      .snp_valid(snp_valid), .snp_addr(snp_addr),
      .cmt_valid(cmt_valid), .cmt_tag(cmt_tag), .st_cmt_valid(st_cmt_valid),
      .cache_rd_en(cache_rd_en), .cache_rd_addr(cache_rd_addr),
      .cache_rd_data(cache_rd_data),
      .cmt_stall(cmt_stall), .retire_valid(retire_valid),
      .squash_valid(squash_valid), .result_tag(result_tag)
   );

   typedef struct packed {
      logic [31:0] addr;
      logic [63:0] data;
      logic        snp;
      logic [31:0] saddr;
      logic [1:0]  busy;
      logic [63:0] cval;
      logic        mark;
      logic        sq;
   } vec_t;

   localparam int NV = 8;
   localparam vec_t TBL [NV] = '{
      '{32'h0000_1000, 64'h1111_2222_3333_4444, 1'b0, 32'h0,         2'd0, 64'h0,                 1'b0, 1'b0}, // R1
      '{32'h0000_2008, 64'hA5A5_0000_FFFF_0001, 1'b1, 32'h0000_2008, 2'd0, 64'hA5A5_0000_FFFF_0001, 1'b1, 1'b0}, // R2 R4
      '{32'h0000_3010, 64'h0000_0000_0000_0007, 1'b1, 32'h0000_3013, 2'd0, 64'h0000_0000_0000_0008, 1'b1, 1'b1}, // R7 R5
      '{32'h0000_4000, 64'hDEAD_BEEF_0000_0000, 1'b1, 32'h0000_4008, 2'd0, 64'h0,                 1'b0, 1'b0}, // R6
      '{32'h0000_5000, 64'h0123_4567_89AB_CDEF, 1'b1, 32'h0000_5000, 2'd2, 64'h0123_4567_89AB_CDEF, 1'b1, 1'b0}, // R3
      '{32'h0000_6018, 64'h8000_0000_0000_0000, 1'b1, 32'h0000_601F, 2'd1, 64'h0,                 1'b1, 1'b1}, // R3 R5
      '{32'h0000_7000, 64'h0000_0000_0000_00FF, 1'b0, 32'h0,         2'd3, 64'h0,                 1'b0, 1'b0}, // R3 unmarked
      '{32'hFFFF_FFF8, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 32'hFFFF_FFF8, 2'd0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b0}  // R2 R4
   };

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic record(input logic [3:0] tag, input logic [31:0] a, input logic [63:0] d);
      @(negedge clk);
      rec_valid = 1'b1; rec_tag = tag; rec_addr = a; rec_data = d;
      @(negedge clk);
      rec_valid = 1'b0;
   endtask

   task automatic snoop(input logic [31:0] a);
      @(negedge clk);
      snp_valid = 1'b1; snp_addr = a;
      @(negedge clk);
      snp_valid = 1'b0;
   endtask

   task automatic commit(input logic [3:0] tag, input int busy, input bit mark,
                         input logic [31:0] ea, input logic [63:0] cval, input bit sq,
                         input string req);
      @(negedge clk);
      cmt_valid = 1'b1; cmt_tag = tag; st_cmt_valid = (busy > 0);
      if (mark) begin
         for (int b = 0; b < busy; b++) begin
            #1;
            chk(cmt_stall == 1'b1, {req, " stall while store owns port"}, cmt_stall, 1);
            chk(cache_rd_en == 1'b0, {req, " no read while store owns port"}, cache_rd_en, 0);
            @(negedge clk);
            st_cmt_valid = (b + 1 < busy);
         end
      end
      #1;
      chk(cmt_stall == 1'b0, {req, " accepted"}, cmt_stall, 0);
      chk(cache_rd_en == mark, {req, " replay read"}, cache_rd_en, mark);
      if (mark) chk(cache_rd_addr == ea, {req, " replay address"}, cache_rd_addr, ea);
      cache_rd_data = cval;
      @(negedge clk);
      cmt_valid = 1'b0; st_cmt_valid = 1'b0;
      #1;
      chk(retire_valid == !sq, {req, " retire"}, retire_valid, !sq);
      chk(squash_valid == sq, {req, " squash"}, squash_valid, sq);
      chk(result_tag == tag, {req, " result tag"}, result_tag, tag);
      if (mark) chk(cmt_stall == 1'b1, {req, " R8 hold after read"}, cmt_stall, 1);
      @(negedge clk);
   endtask

   initial begin
      #(5.0 * 100000);
      n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R9 reset state
      chk(retire_valid == 0, "R9 retire low", retire_valid, 0);
      chk(squash_valid == 0, "R9 squash low", squash_valid, 0);
      chk(cache_rd_en == 0, "R9 read low", cache_rd_en, 0);
      chk(cmt_stall == 0, "R9 stall low", cmt_stall, 0);

      for (int i = 0; i < NV; i++) begin
         record(4'(i), TBL[i].addr, TBL[i].data);
         if (TBL[i].snp) snoop(TBL[i].saddr);
         commit(4'(i), int'(TBL[i].busy), TBL[i].mark, TBL[i].addr,
                TBL[i].cval, TBL[i].sq, $sformatf("vec%0d", i));
      end

      // R10: snoop in the recording cycle marks the load
      @(negedge clk);
      rec_valid = 1'b1; rec_tag = 4'd9; rec_addr = 32'h0000_9000; rec_data = 64'h55;
      snp_valid = 1'b1; snp_addr = 32'h0000_9004;
      @(negedge clk);
      rec_valid = 1'b0; snp_valid = 1'b0;
      commit(4'd9, 0, 1'b1, 32'h0000_9000, 64'h56, 1'b1, "R10");

      // R11: re-recording a marked slot clears the mark
      record(4'd10, 32'h0000_A000, 64'h1);
      snoop(32'h0000_A000);
      record(4'd10, 32'h0000_A000, 64'h2);
      commit(4'd10, 0, 1'b0, 32'h0, 64'h0, 1'b0, "R11");

      // R8: back-to-back unmarked commits
      record(4'd12, 32'h0000_C000, 64'h12);
      record(4'd13, 32'h0000_D000, 64'h13);
      @(negedge clk);
      cmt_valid = 1'b1; cmt_tag = 4'd12;
      #1;
      chk(cmt_stall == 0, "R8 first accepted", cmt_stall, 0);
      @(negedge clk);
      cmt_tag = 4'd13;
      #1;
      chk(cmt_stall == 0, "R8 second accepted", cmt_stall, 0);
      chk(retire_valid == 1 && result_tag == 4'd12, "R8 first retire",
          {retire_valid, result_tag}, {1'b1, 4'd12});
      @(negedge clk);
      cmt_valid = 1'b0;
      #1;
      chk(retire_valid == 1 && result_tag == 4'd13, "R8 second retire",
          {retire_valid, result_tag}, {1'b1, 4'd13});
      @(negedge clk);
      #1;
      chk(retire_valid == 0 && squash_valid == 0, "R1 idle after retire",
          {retire_valid, squash_valid}, 0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule